// File: doc/BRIEF.md
# Machine-Mode Control Register Bank

This block keeps the machine-level control and status registers of a 32-bit RISC-V core. These registers sit in their own 12-bit address space, apart from the integer register file. The decoder hands over four things: a register address, a 3-bit operation code, the rs1 value together with the 5-bit immediate field, and two flags that say whether the destination or the source register field names x0. The block returns the register's previous contents in the same cycle, for write-back to rd. The modified value is committed at the next rising clock edge, so every access is an indivisible read-modify-write.

A second write path belongs to the interrupt logic. In a single cycle it loads the status, exception-PC and cause registers together. When it is active, any register write requested by an instruction in that cycle is dropped. The status, trap-vector and exception-PC registers are also driven straight out to the interrupt logic.

Top module: `mcsr_bank`

## Requirements
- R1: `op_i` is decoded as 3'b001 swap, 3'b010 set-bits, 3'b011 clear-bits, 3'b101 swap-immediate, 3'b110 set-immediate and 3'b111 clear-immediate. Codes 3'b000 and 3'b100 are no operation. Both swap forms store the new value unconditionally at the next rising edge: `src_i` for the register form, and `zimm_i` zero-extended to 32 bits for the immediate form.
- R2: `rdata_o` combinationally shows the addressed register's present value, zero-extended, for any valid operation. It is 0 for the two no-operation codes, and for the swap forms when `rd_zero_i` is 1. The write still happens in that case.
- R3: Set-bits stores old | `src_i`. Clear-bits stores old & ~`src_i`. When `rs1_zero_i` is 1, neither form writes.
- R4: Set-immediate and clear-immediate use `zimm_i` zero-extended as the mask. When `zimm_i` is 0, neither form writes.
- R5: The implemented addresses are 0x300 status, 0x304 interrupt enable, 0x305 trap vector, 0x340 scratch, 0x341 exception PC and 0x342 cause. Any other address reads 0, and a write to it changes no register.
- R6: When `irq_we_i` is 1, the status, exception-PC and cause registers take `irq_status_i`, `irq_epc_i` and `irq_cause_i` at the next rising edge.
- R7: When `irq_we_i` is 1, no instruction write takes place in that cycle, whatever the address.
- R8: After reset (`rst_n` low) all six registers hold 0.
- R9: `mstatus_o`, `mtvec_o` and `mepc_o` always show the current contents of the status, trap-vector and exception-PC registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (see R1) |
| addr_i | input | 12 | Register address |
| src_i | input | 32 | rs1 value |
| zimm_i | input | 5 | Immediate taken from the rs1 field |
| rd_zero_i | input | 1 | Destination field is x0 |
| rs1_zero_i | input | 1 | Source field is x0 |
| rdata_o | output | 32 | Old register value for rd |
| irq_we_i | input | 1 | Interrupt-logic multi-register write |
| irq_status_i | input | 32 | New status value from the interrupt logic |
| irq_epc_i | input | 32 | New exception PC from the interrupt logic |
| irq_cause_i | input | 32 | New cause value from the interrupt logic |
| mstatus_o | output | 32 | Current status register |
| mtvec_o | output | 32 | Current trap-vector register |
| mepc_o | output | 32 | Current exception-PC register |

## Verification
The bench builds the block with its default parameters: a 32-bit data width, a 5-bit immediate and the standard addresses. At these values every immediate mask can reach every bit that a 5-bit field can touch. Unused addresses such as 0x343, 0x000 and 0xFFF are in the address pool, so ignored writes get exercised next to real ones. The bench compares against an address-keyed model on every clock. Directed steps cover the x0 and zero-immediate suppression cases and the cycles in which an interrupt write collides with an instruction write. A random phase then mixes all eight operation codes with occasional interrupt writes.

// File: rtl/mcsr_bank.sv
module mcsr_bank #(
  parameter int XLEN = 32,
  parameter int AW = 12,
  parameter int ZW = 5,
  parameter logic [AW-1:0] A_STATUS  = 12'h300,
  parameter logic [AW-1:0] A_IE      = 12'h304,
  parameter logic [AW-1:0] A_TVEC    = 12'h305,
  parameter logic [AW-1:0] A_SCRATCH = 12'h340,
  parameter logic [AW-1:0] A_EPC     = 12'h341,
  parameter logic [AW-1:0] A_CAUSE   = 12'h342
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [ZW-1:0]   zimm_i,
  input  logic            rd_zero_i,
  input  logic            rs1_zero_i,
  output logic [XLEN-1:0] rdata_o,
  input  logic            irq_we_i,
  input  logic [XLEN-1:0] irq_status_i,
  input  logic [XLEN-1:0] irq_epc_i,
  input  logic [XLEN-1:0] irq_cause_i,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] mepc_o
);
  localparam int NREG = 6;
  localparam logic [2:0] S_STATUS = 3'd0, S_IE = 3'd1, S_TVEC = 3'd2,
                         S_SCRATCH = 3'd3, S_EPC = 3'd4, S_CAUSE = 3'd5,
                         S_NONE = 3'd7;

  logic [XLEN-1:0] regs [NREG];
  logic [2:0]      sel;
  logic [XLEN-1:0] old, mask, wnew;
  logic [1:0]      kind;
  logic            is_imm, valid, mask_zero, wen;

  always_comb begin
    case (addr_i)
      A_STATUS:  sel = S_STATUS;
      A_IE:      sel = S_IE;
      A_TVEC:    sel = S_TVEC;
      A_SCRATCH: sel = S_SCRATCH;
      A_EPC:     sel = S_EPC;
      A_CAUSE:   sel = S_CAUSE;
      default:   sel = S_NONE;
    endcase
  end

  assign old       = (sel == S_NONE) ? '0 : regs[sel];
  assign is_imm    = op_i[2];
  assign kind      = op_i[1:0];
  assign valid     = (kind != 2'b00);
  assign mask      = is_imm ? {{(XLEN-ZW){1'b0}}, zimm_i} : src_i;
  assign mask_zero = is_imm ? (zimm_i == '0) : rs1_zero_i;

  always_comb begin
    case (kind)
      2'b01:   wnew = mask;
      2'b10:   wnew = old | mask;
      2'b11:   wnew = old & ~mask;
      default: wnew = old;
    endcase
  end

  assign wen     = valid && (sel != S_NONE) && !irq_we_i && (kind == 2'b01 || !mask_zero);
  assign rdata_o = (valid && !(kind == 2'b01 && rd_zero_i)) ? old : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (irq_we_i) begin
      regs[S_STATUS] <= irq_status_i;
      regs[S_EPC]    <= irq_epc_i;
      regs[S_CAUSE]  <= irq_cause_i;
    end else if (wen) begin
      regs[sel] <= wnew;
    end
  end

  assign mstatus_o = regs[S_STATUS];
  assign mtvec_o   = regs[S_TVEC];
  assign mepc_o    = regs[S_EPC];

  assert_irq_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_we_i |=> mepc_o == $past(irq_epc_i));
  assert_irq_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_we_i && addr_i == A_TVEC) |=> $stable(mtvec_o));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_we_i && op_i == 3'b011 && addr_i == A_STATUS && !rs1_zero_i)
      |=> mstatus_o == ($past(mstatus_o) & ~$past(src_i)));
  assert_set_x0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_we_i && op_i == 3'b010 && rs1_zero_i && addr_i == A_STATUS) |=> $stable(mstatus_o));
  assert_unmapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_we_i && sel == S_NONE) |=> ($stable(mstatus_o) && $stable(mtvec_o) && $stable(mepc_o)));
  assert_imm_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_we_i && op_i == 3'b110 && zimm_i == '0 && addr_i == A_EPC) |=> $stable(mepc_o));

  always @(posedge clk)
    if (rst_n && op_i == 3'b010 && addr_i == A_TVEC)
      assert_read_view_R9: assert (rdata_o == mtvec_o);
endmodule

// File: tb/mcsr_bank_test.sv
module mcsr_bank_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] op_i = 0;
  logic [11:0] addr_i = 0;
  logic [31:0] src_i = 0;
  logic [4:0] zimm_i = 0;
  logic rd_zero_i = 0, rs1_zero_i = 0, irq_we_i = 0;
  logic [31:0] irq_status_i = 0, irq_epc_i = 0, irq_cause_i = 0;
  logic [31:0] rdata_o, mstatus_o, mtvec_o, mepc_o;
  int checks = 0, errors = 0;
  bit done = 0;
  bit [31:0] m [int];
  int pool [9] = '{'h300, 'h304, 'h305, 'h340, 'h341, 'h342, 'h343, 'h000, 'hFFF};

  always #10 clk = ~clk;

  mcsr_bank uut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .src_i(src_i),
    .zimm_i(zimm_i), .rd_zero_i(rd_zero_i), .rs1_zero_i(rs1_zero_i), .rdata_o(rdata_o),
    .irq_we_i(irq_we_i), .irq_status_i(irq_status_i), .irq_epc_i(irq_epc_i),
    .irq_cause_i(irq_cause_i), .mstatus_o(mstatus_o), .mtvec_o(mtvec_o), .mepc_o(mepc_o));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] rd(int a);
    return m.exists(a) ? m[a] : 32'h0;
  endfunction

  task automatic step(string tag, bit [2:0] op, int a, bit [31:0] s, bit [4:0] z,
                      bit rdz, bit r1z, bit irq, bit [31:0] is, bit [31:0] ie, bit [31:0] ic);
    bit [31:0] old, msk, nv, er;
    bit wr;
    @(negedge clk);
    op_i = op; addr_i = a[11:0]; src_i = s; zimm_i = z; rd_zero_i = rdz; rs1_zero_i = r1z;
    irq_we_i = irq; irq_status_i = is; irq_epc_i = ie; irq_cause_i = ic;
    #2;
    old = rd(a);
    er = (op[1:0] == 0 || (op[1:0] == 1 && rdz)) ? 32'h0 : old;
    check({tag, " R2 rdata"}, rdata_o, er);
    check({tag, " R9 status"}, mstatus_o, rd('h300));
    check({tag, " R9 tvec"}, mtvec_o, rd('h305));
    check({tag, " R9 epc"}, mepc_o, rd('h341));
    msk = op[2] ? {27'h0, z} : s;
    wr = 0; nv = old;
    case (op[1:0])
      2'b01: begin wr = 1; nv = msk; end
      2'b10: begin wr = op[2] ? (z != 0) : !r1z; nv = old | msk; end
      2'b11: begin wr = op[2] ? (z != 0) : !r1z; nv = old & ~msk; end
      default: wr = 0;
    endcase
    @(posedge clk);
    if (irq) begin m['h300] = is; m['h341] = ie; m['h342] = ic; end
    else if (wr && m.exists(a)) m[a] = nv;
  endtask

  task automatic op(string tag, bit [2:0] o, int a, bit [31:0] s, bit [4:0] z, bit rdz, bit r1z);
    step(tag, o, a, s, z, rdz, r1z, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (pool[i]) if (i < 6) m[pool[i]] = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R8 reset contents, read with non-writing set-bits
    foreach (pool[i]) op("R8 reset", 3'b010, pool[i], 32'hFFFF_FFFF, 0, 0, 1);
    // R1 swap forms
    op("R1 swap", 3'b001, 'h305, 32'h8000_0100, 0, 0, 0);
    op("R1 swapi", 3'b101, 'h340, 32'hFFFF_FFFF, 5'h15, 0, 0);
    op("R1 readback", 3'b010, 'h340, 0, 0, 0, 1);
    // R2 swap with rd x0: no read value, still writes
    op("R2 rdx0", 3'b001, 'h300, 32'h0000_1888, 0, 1, 0);
    op("R2 after", 3'b010, 'h300, 0, 0, 0, 1);
    // R3 set/clear and x0 suppression
    op("R3 set", 3'b010, 'h300, 32'h0000_0008, 0, 0, 0);
    op("R3 clear", 3'b011, 'h300, 32'h0000_0080, 0, 0, 0);
    op("R3 setx0", 3'b010, 'h300, 32'hFFFF_FFFF, 0, 0, 1);
    op("R3 clrx0", 3'b011, 'h305, 32'hFFFF_FFFF, 0, 0, 1);
    // R4 immediate masks
    op("R4 seti", 3'b110, 'h304, 0, 5'h1F, 0, 0);
    op("R4 clri", 3'b111, 'h304, 32'hFFFF_FFFF, 5'h05, 0, 0);
    op("R4 seti0", 3'b110, 'h341, 32'hFFFF_FFFF, 0, 0, 0);
    op("R4 clri0", 3'b111, 'h304, 0, 0, 0, 0);
    // R5 unmapped
    op("R5 wr343", 3'b001, 'h343, 32'hDEAD_BEEF, 0, 0, 0);
    op("R5 rd343", 3'b010, 'h343, 0, 0, 0, 1);
    op("R5 wrFFF", 3'b110, 'hFFF, 0, 5'h1F, 0, 0);
    // R6/R7 interrupt write and collisions
    step("R6 irq", 3'b000, 'h300, 0, 0, 0, 0, 1, 32'h0000_1800, 32'h0000_2004, 32'h8000_000B);
    op("R6 cause", 3'b010, 'h342, 0, 0, 0, 1);
    step("R7 vs epc", 3'b001, 'h341, 32'h1234_5678, 0, 0, 0, 1, 32'h11, 32'h0000_3000, 32'h7);
    step("R7 vs tvec", 3'b001, 'h305, 32'hAAAA_0000, 0, 0, 0, 1, 32'h22, 32'h0000_4000, 32'h3);
    op("R7 epc", 3'b010, 'h341, 0, 0, 0, 1);
    op("R7 tvec", 3'b010, 'h305, 0, 0, 0, 1);
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      step("RND", 3'($urandom), pool[$urandom % 9], $urandom, 5'($urandom),
           1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 1'($urandom % 8 == 0),
           $urandom, $urandom, $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule